// File: doc/BRIEF.md
# Bus-Inversion Codec for an Active-Low 64-Bit Data Path

This block encodes and decodes bus inversion on a 64-bit data path whose lines are active low. A logical one drives a line electrically low, and a low line draws current. The path is split into four 16-bit lanes, and each lane has its own inversion flag. The flag is also active low. The transmit side takes a 64-bit logical word and works out, for each lane, how many of the lane's lines would sit electrically low. If that number is more than half the lane width, the lane is sent inverted and its flag line is pulled low. The receive side takes the electrical pattern and the four flag lines and restores the logical word.

Every transfer is judged on its own. Each sub-phase of a multi-pumped transfer gets a fresh decision for each lane, and the block keeps no history between transfers. Lane widths, lane count and the output stage are set by parameters. With `REG_OUT` set (the default), the encoder results pass through one register stage and a valid bit travels with them. With `REG_OUT` cleared, the encoder is purely combinational. The receive path is always combinational.

The block has no state machine. Its only sequential element is the optional register stage, which holds either the reset (idle) pattern or the result of the last transfer.

Top module: `dbi_codec`

## Requirements
- R1: Lane k covers data bits [16k+15:16k] and is paired with flag bit k, for k = 0..3 (lane 0 = bits 15:0 with flag 0, lane 3 = bits 63:48 with flag 3).
- R2: All lines are active low. When a lane is not inverted, its flag line is 1 (deasserted) and its bus lines are the bitwise complement of the logical data.
- R3: When a lane's logical data has more than 8 ones, that is, more than 8 of its lines would be driven low, the lane is inverted. Its bus lines then equal the logical data and its flag line is 0 (asserted).
- R4: A lane with exactly 8 ones is not inverted, and its flag line is 1.
- R5: Each lane's decision depends only on that lane's own 16 bits. Changing one lane leaves the bus lines and flags of the other lanes unchanged.
- R6: On receive, a lane whose flag line is 0 gives logical data equal to its bus lines. A lane whose flag line is 1 gives the complement of its bus lines.
- R7: Feeding the encoder outputs into the decoder returns the original 64-bit word for every input.
- R8: After encoding, no lane has more than 8 of its 16 bus lines at 0.
- R9: With REG_OUT=1, the encoder bus, flags and valid appear one clock after the inputs. During reset (rst_n low, asynchronous), the outputs are all bus lines 1, all flags 1, and valid 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid_i | input | 1 | Transmit word is valid this cycle |
| tx_data_i | input | 64 | Logical transmit word |
| tx_bus_o | output | 64 | Electrical levels to drive on the data lines |
| tx_flag_n_o | output | 4 | Electrical inversion flag per lane, 0 = inverted |
| tx_valid_o | output | 1 | Valid bit aligned with tx_bus_o and tx_flag_n_o |
| rx_bus_i | input | 64 | Electrical levels sampled from the data lines |
| rx_flag_n_i | input | 4 | Electrical inversion flags sampled per lane |
| rx_data_o | output | 64 | Restored logical receive word |

## Verification
The encoder is driven with words whose lanes hold 0, 8, 9 and 16 ones. These separate the strict more-than-half threshold from an at-least-half threshold, and they show that an all-ones lane is inverted. Words that change only one lane show that the lanes decide independently, and that no lane's decision is tied to the wrong flag bit. The decoder is driven with arbitrary bus and flag patterns that are not encoder outputs, so that the two polarities are told apart. Several hundred seeded random words are then looped from encoder to decoder to check the round trip and the limit of 8 low lines per lane.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    // Default geometry of the data path
    localparam int LANE_W_DEF  = 16;
    localparam int LANE_N_DEF  = 4;

    // Electrical level of an inversion flag line (active low)
    typedef enum logic {
        FLAG_ASSERTED = 1'b0,
        FLAG_IDLE     = 1'b1
    } flag_lvl_e;

endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
    import dbi_pkg::*;
#(
    parameter  int LANE_W = LANE_W_DEF,
    localparam int CNT_W  = $clog2(LANE_W + 1),
    localparam int HALF   = LANE_W / 2
) (
    input  logic [LANE_W-1:0] data_i,
    output logic [LANE_W-1:0] bus_o,
    output logic              flag_n_o
);

    logic [CNT_W-1:0] low_cnt;
    logic             do_inv;

    // Logical ones are the lines that would sit electrically low
    always_comb begin
        low_cnt = '0;
        for (int i = 0; i < LANE_W; i++) begin
            low_cnt = low_cnt + CNT_W'(data_i[i]);
        end
    end

    // Strictly more than half: a tie stays uninverted
    assign do_inv   = (int'(low_cnt) > HALF);
    assign bus_o    = do_inv ? data_i : ~data_i;
    assign flag_n_o = do_inv ? logic'(FLAG_ASSERTED) : logic'(FLAG_IDLE);

endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec
    import dbi_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic [LANE_W-1:0] bus_i,
    input  logic              flag_n_i,
    output logic [LANE_W-1:0] data_o
);

    logic lane_inverted;

    assign lane_inverted = (flag_n_i == logic'(FLAG_ASSERTED));
    // An inverted lane already carries logical levels; otherwise undo active-low
    assign data_o = lane_inverted ? bus_i : ~bus_i;

endmodule

// File: rtl/dbi_out_stage.sv
module dbi_out_stage
    import dbi_pkg::*;
#(
    parameter int  DATA_W  = LANE_W_DEF * LANE_N_DEF,
    parameter int  FLAG_W  = LANE_N_DEF,
    parameter bit  REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] bus_i,
    input  logic [FLAG_W-1:0] flag_n_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] bus_o,
    output logic [FLAG_W-1:0] flag_n_o
);

    generate
        if (REG_OUT) begin : g_reg
            // Idle pattern: no line pulled low, no flag asserted
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_o  <= 1'b0;
                    bus_o    <= '1;
                    flag_n_o <= {FLAG_W{logic'(FLAG_IDLE)}};
                end else begin
                    valid_o  <= valid_i;
                    bus_o    <= bus_i;
                    flag_n_o <= flag_n_i;
                end
            end
        end else begin : g_comb
            assign valid_o  = valid_i;
            assign bus_o    = bus_i;
            assign flag_n_o = flag_n_i;
        end
    endgenerate

endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
    import dbi_pkg::*;
#(
    parameter  int LANE_W  = LANE_W_DEF,
    parameter  int LANE_N  = LANE_N_DEF,
    parameter  bit REG_OUT = 1'b1,
    localparam int DATA_W  = LANE_W * LANE_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic [DATA_W-1:0] tx_bus_o,
    output logic [LANE_N-1:0] tx_flag_n_o,
    output logic              tx_valid_o,
    input  logic [DATA_W-1:0] rx_bus_i,
    input  logic [LANE_N-1:0] rx_flag_n_i,
    output logic [DATA_W-1:0] rx_data_o
);

    logic [DATA_W-1:0] enc_bus;
    logic [LANE_N-1:0] enc_flag_n;

    generate
        for (genvar g = 0; g < LANE_N; g++) begin : g_lane
            dbi_lane_enc #(.LANE_W(LANE_W)) u_enc (
                .data_i   (tx_data_i[g*LANE_W +: LANE_W]),
                .bus_o    (enc_bus[g*LANE_W +: LANE_W]),
                .flag_n_o (enc_flag_n[g])
            );

            dbi_lane_dec #(.LANE_W(LANE_W)) u_dec (
                .bus_i    (rx_bus_i[g*LANE_W +: LANE_W]),
                .flag_n_i (rx_flag_n_i[g]),
                .data_o   (rx_data_o[g*LANE_W +: LANE_W])
            );
        end
    endgenerate

    dbi_out_stage #(
        .DATA_W  (DATA_W),
        .FLAG_W  (LANE_N),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (tx_valid_i),
        .bus_i    (enc_bus),
        .flag_n_i (enc_flag_n),
        .valid_o  (tx_valid_o),
        .bus_o    (tx_bus_o),
        .flag_n_o (tx_flag_n_o)
    );

endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk #(
    parameter  int LANE_W  = 16,
    parameter  int LANE_N  = 4,
    parameter  bit REG_OUT = 1'b1,
    localparam int DATA_W  = LANE_W * LANE_N,
    localparam int HALF    = LANE_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid_i,
    input logic [DATA_W-1:0] tx_data_i,
    input logic [DATA_W-1:0] tx_bus_o,
    input logic [LANE_N-1:0] tx_flag_n_o,
    input logic              tx_valid_o,
    input logic [DATA_W-1:0] rx_bus_i,
    input logic [LANE_N-1:0] rx_flag_n_i,
    input logic [DATA_W-1:0] rx_data_o
);

    // Word that the encoder outputs currently describe
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] src_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= tx_data_i;
    end

    assign src_w = REG_OUT ? src_q : tx_data_i;

    generate
        for (genvar g = 0; g < LANE_N; g++) begin : g_chk
            AST_LANE_LOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
                tx_valid_o |-> ((LANE_W - $countones(tx_bus_o[g*LANE_W +: LANE_W])) <= HALF)); // R8

            AST_LANE_FLAG_RULE: assert property (@(posedge clk) disable iff (!rst_n)
                tx_valid_o |-> ((tx_flag_n_o[g] == 1'b0) ==
                               ($countones(src_w[g*LANE_W +: LANE_W]) > HALF))); // R3

            AST_LANE_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
                tx_valid_o |-> ((tx_flag_n_o[g] ? ~tx_bus_o[g*LANE_W +: LANE_W]
                                                :  tx_bus_o[g*LANE_W +: LANE_W])
                                == src_w[g*LANE_W +: LANE_W])); // R7

            AST_RX_WHOLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(rx_data_o[g*LANE_W +: LANE_W] ^ rx_bus_i[g*LANE_W +: LANE_W]) == 0) ||
                ($countones(rx_data_o[g*LANE_W +: LANE_W] ^ rx_bus_i[g*LANE_W +: LANE_W]) == LANE_W)); // R6
        end

        if (REG_OUT) begin : g_pipe_chk
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                tx_valid_i |=> tx_valid_o); // R9

            AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                !tx_valid_i |=> !tx_valid_o); // R9
        end
    endgenerate

endmodule

bind dbi_codec dbi_codec_chk #(
    .LANE_W  (LANE_W),
    .LANE_N  (LANE_N),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid_i  (tx_valid_i),
    .tx_data_i   (tx_data_i),
    .tx_bus_o    (tx_bus_o),
    .tx_flag_n_o (tx_flag_n_o),
    .tx_valid_o  (tx_valid_o),
    .rx_bus_i    (rx_bus_i),
    .rx_flag_n_i (rx_flag_n_i),
    .rx_data_o   (rx_data_o)
);

// File: tb/tb_dbi_codec.sv
`timescale 1ns/1ps
module tb_dbi_codec;

    localparam int LW = 16;
    localparam int LN = 4;
    localparam int DW = LW * LN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_valid_i = 1'b0;
    logic [DW-1:0] tx_data_i = '0;
    logic [DW-1:0] tx_bus_o;
    logic [LN-1:0] tx_flag_n_o;
    logic          tx_valid_o;
    logic [DW-1:0] rx_bus_i = '0;
    logic [LN-1:0] rx_flag_n_i = '1;
    logic [DW-1:0] rx_data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dbi_codec dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
        .tx_bus_o(tx_bus_o), .tx_flag_n_o(tx_flag_n_o), .tx_valid_o(tx_valid_o),
        .rx_bus_i(rx_bus_i), .rx_flag_n_i(rx_flag_n_i), .rx_data_o(rx_data_o)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected encoder result from the requirement text
    function automatic logic [DW-1:0] exp_bus(input logic [DW-1:0] d);
        logic [DW-1:0] r;
        for (int g = 0; g < LN; g++) begin
            if ($countones(d[g*LW +: LW]) > LW/2) r[g*LW +: LW] = d[g*LW +: LW];
            else                                  r[g*LW +: LW] = ~d[g*LW +: LW];
        end
        return r;
    endfunction

    function automatic logic [LN-1:0] exp_flag(input logic [DW-1:0] d);
        logic [LN-1:0] f;
        for (int g = 0; g < LN; g++) f[g] = !($countones(d[g*LW +: LW]) > LW/2);
        return f;
    endfunction

    function automatic bit lanes_within_limit(input logic [DW-1:0] b);
        for (int g = 0; g < LN; g++)
            if (LW - $countones(b[g*LW +: LW]) > LW/2) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [DW-1:0] exp_rx(input logic [DW-1:0] b, input logic [LN-1:0] f);
        logic [DW-1:0] r;
        for (int g = 0; g < LN; g++) r[g*LW +: LW] = f[g] ? ~b[g*LW +: LW] : b[g*LW +: LW];
        return r;
    endfunction

    // Drive a word, check registered encoder outputs one cycle later, then loop back
    task automatic send(input logic [DW-1:0] d, input string req);
        @(negedge clk);
        tx_data_i  = d;
        tx_valid_i = 1'b1;
        @(negedge clk);
        check(tx_bus_o == exp_bus(d), req, tx_bus_o, exp_bus(d));
        check(tx_flag_n_o == exp_flag(d), req, DW'(tx_flag_n_o), DW'(exp_flag(d)));
        check(tx_valid_o == 1'b1, "R9 valid", DW'(tx_valid_o), DW'(1));
        check(lanes_within_limit(tx_bus_o), "R8 low limit", tx_bus_o, exp_bus(d));
        rx_bus_i    = tx_bus_o;
        rx_flag_n_i = tx_flag_n_o;
        #1;
        check(rx_data_o == d, "R7 roundtrip", rx_data_o, d);
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] b0;
        logic [LN-1:0] f0;
        void'($urandom(32'h5EED_0042));

        // R9: reset state
        #23;
        check(tx_bus_o == '1, "R9 reset bus", tx_bus_o, '1);
        check(tx_flag_n_o == '1, "R9 reset flags", DW'(tx_flag_n_o), DW'(4'hF));
        check(tx_valid_o == 1'b0, "R9 reset valid", DW'(tx_valid_o), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: all zero, nothing inverted, lines are the complement
        send('0, "R2 all zero");
        // R3: all ones in every lane, every lane inverted
        send('1, "R3 all ones");
        // R4: exactly 8 ones per lane, tie stays uninverted
        send({4{16'h00FF}}, "R4 tie");
        send({4{16'hA5A5}}, "R4 tie pattern");
        // R3: 9 ones per lane crosses the threshold
        send({4{16'h01FF}}, "R3 nine ones");
        // R1 / R5: only one lane over threshold at a time
        for (int g = 0; g < LN; g++) begin
            v = '0;
            v[g*LW +: LW] = 16'hFFFE;
            send(v, "R1 lane map");
            check(tx_flag_n_o == ~(LN'(1) << g), "R1 flag index", DW'(tx_flag_n_o),
                  DW'(~(LN'(1) << g)));
        end
        // R5: change lane 2 only, other lanes must keep their levels
        send(64'h1234_00FF_FFFF_0F0F, "R5 base");
        b0 = tx_bus_o; f0 = tx_flag_n_o;
        send(64'h1234_FFFF_FFFF_0F0F, "R5 lane2 changed");
        check({tx_bus_o[63:48], tx_bus_o[31:0]} == {b0[63:48], b0[31:0]}, "R5 other lanes",
              tx_bus_o, b0);
        check({tx_flag_n_o[3], tx_flag_n_o[1:0]} == {f0[3], f0[1:0]}, "R5 other flags",
              DW'(tx_flag_n_o), DW'(f0));

        // R9: output holds until the clock edge, valid drops one cycle after input
        @(negedge clk);
        b0 = tx_bus_o;
        tx_data_i = 64'h0;
        tx_valid_i = 1'b0;
        #1;
        check(tx_bus_o == b0, "R9 one cycle latency", tx_bus_o, b0);
        @(negedge clk);
        check(tx_valid_o == 1'b0, "R9 valid drop", DW'(tx_valid_o), '0);

        // R6: decoder polarity on arbitrary patterns
        rx_bus_i = 64'hDEAD_BEEF_0123_4567;
        rx_flag_n_i = 4'b0101;
        #1;
        check(rx_data_o == exp_rx(rx_bus_i, rx_flag_n_i), "R6 mixed flags", rx_data_o,
              exp_rx(rx_bus_i, rx_flag_n_i));
        rx_flag_n_i = 4'b0000;
        #1;
        check(rx_data_o == rx_bus_i, "R6 all asserted", rx_data_o, rx_bus_i);
        rx_flag_n_i = 4'b1111;
        #1;
        check(rx_data_o == ~rx_bus_i, "R6 all idle", rx_data_o, ~rx_bus_i);

        // R7 / R8: seeded random words
        for (int n = 0; n < 400; n++) begin
            v = {$urandom(), $urandom()};
            if (n % 4 == 1) v = v | {$urandom(), $urandom()};
            if (n % 4 == 2) v = v & {$urandom(), $urandom()};
            send(v, "R7 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule